// File: doc/BRIEF.md
# Triple Prescaled Event Timer Unit

This block holds three independent interval timers for a small sound-processor subsystem. Each timer takes a fixed-rate tick from a shared clock prescaler and counts those ticks in an 8-bit internal divider. When the divider reaches the programmed period it restarts from zero and bumps a 4-bit event counter. The CPU polls that event counter to learn how many intervals have elapsed since its last look. Timers 0 and 1 run from a slow prescaler. Timer 2 runs from a faster one.

Software programs the block through a small register window. One control byte turns each timer on or off, three target registers set the periods, and three counter registers return the event counts. Reading a counter register also clears it, so each read reports only the events since the previous read. The port is plain, with no handshake. A write takes effect at the clock edge that ends its cycle. Read data appears on `rd_data` in the cycle after the read strobe.

Top module: `tick_timer_trio`

## Requirements
- R1: After reset every timer is disabled, every target is 0 (period 256), and every event counter and divider is 0.
- R2: Bit i of the control register (address 0), for i in 0..2, enables timer i. While a timer is disabled, its divider and counter hold their values.
- R3: The prescaler counts clocks from the release of reset. Timers 0 and 1 get a tick on every clock edge whose 1-based index after reset release is a multiple of SLOW_DIV. Timer 2 gets a tick on every edge whose index is a multiple of FAST_DIV.
- R4: Each tick seen by an enabled timer advances its divider by one. When the divider would reach the period, it returns to 0 instead and the 4-bit counter increments modulo 16.
- R5: The target for timer i is written at address 1+i. A target of 0 means a period of 256, and any other value is the period itself.
- R6: A read strobe at address 4+i places {4'b0, counter i} on rd_data in the next cycle and clears counter i at the same edge.
- R7: Any write to address 4+i clears counter i, whatever the written data.
- R8: A control write that takes a timer's enable from 0 to 1 clears that timer's divider and counter. A control write with the bit already set leaves them untouched.
- R9: If a counter is cleared in the same cycle that it would increment, it ends at 1, so no event is lost.
- R10: A read of address 0, 1, 2, 3 or 7 returns 0 on rd_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address for the current read or write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
A clear can fall in the same cycle as an increment, whether the clear comes from a counter read or from a counter write. The bench sets a period of 1 and uses its own model of the prescaler phase to find the cycle before a tick edge. It issues the read in exactly that cycle, then reads again one cycle later and expects exactly 1. The clear that comes with an enable turning on is tested separately. There a period of 3 guarantees that no increment can follow within one cycle, so the expected count is exactly 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR = 3;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int TGT_W   = 8;
  localparam int CNT_W   = 4;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t A_CTRL = 3'd0;
  localparam reg_addr_t A_TGT0 = 3'd1;
  localparam reg_addr_t A_CNT0 = 3'd4;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_chk
      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int TGT_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             en_rise_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             tgt_we_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [TGT_W-1:0] tgt_q;
  logic [TGT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TGT_W:0]   period;
  logic [TGT_W:0]   div_nxt;
  logic             hit;
  logic             inc;

  assign period  = {(tgt_q == '0), tgt_q};
  assign div_nxt = {1'b0, div_q} + 1'b1;
  assign hit     = (div_nxt == period);
  assign inc     = en_i && tick_i && hit;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tgt_q <= '0;
    else if (tgt_we_i) tgt_q <= tgt_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (en_rise_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (en_i && tick_i) div_q <= hit ? '0 : div_nxt[TGT_W-1:0];
      if (clr_i)    cnt_q <= inc ? CNT_W'(1) : '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_rise_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R2
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !en_rise_i && !clr_i) |=> ($stable(cnt_q) && $stable(div_q)));

  // R8
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise_i |=> (cnt_q == '0 && div_q == '0));

  // R9
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !en_rise_i) |=> (cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/tick_timer_trio.sv
module tick_timer_trio
  import tmr_pkg::*;
#(
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 16,
  parameter logic [NUM_TMR-1:0] FAST_MASK = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic               slow_tick;
  logic               fast_tick;
  logic [NUM_TMR-1:0] ctrl_q;
  logic [NUM_TMR-1:0] en_rise;
  logic [NUM_TMR-1:0] clr;
  logic [NUM_TMR-1:0] tgt_we;
  logic [NUM_TMR-1:0] tick;
  logic [CNT_W-1:0]   cnt [NUM_TMR];
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  rd_q;
  logic               ctrl_we;

  tmr_prescale #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst_n(rst_n), .tick_o(slow_tick));
  tmr_prescale #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst_n(rst_n), .tick_o(fast_tick));

  assign ctrl_we = wr_en && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wr_data[NUM_TMR-1:0];
  end

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      localparam reg_addr_t TGT_A = reg_addr_t'(A_TGT0 + i);
      localparam reg_addr_t CNT_A = reg_addr_t'(A_CNT0 + i);

      if (FAST_MASK[i]) begin : g_fast
        assign tick[i] = fast_tick;
      end else begin : g_slow
        assign tick[i] = slow_tick;
      end

      assign en_rise[i] = ctrl_we && wr_data[i] && !ctrl_q[i];
      assign clr[i]     = (wr_en || rd_en) && (bus_addr == CNT_A);
      assign tgt_we[i]  = wr_en && (bus_addr == TGT_A);

      tmr_channel #(.TGT_W(TGT_W), .CNT_W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl_q[i]),
        .en_rise_i(en_rise[i]),
        .tick_i   (tick[i]),
        .clr_i    (clr[i]),
        .tgt_we_i (tgt_we[i]),
        .tgt_i    (wr_data[TGT_W-1:0]),
        .cnt_o    (cnt[i])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr == reg_addr_t'(A_CNT0 + i)) rd_next = DATA_W'(cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  // R6
  rd_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[DATA_W-1:CNT_W] == '0));

  // R10
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (bus_addr < A_CNT0 || bus_addr == reg_addr_t'(A_CNT0 + NUM_TMR))) |=> (rd_data == '0));
endmodule

// File: tb/tick_timer_trio_tb.sv
`timescale 1ns/1ps
module tick_timer_trio_tb;
  localparam int SLOW = 4;
  localparam int FAST = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer_trio #(.SLOW_DIV(SLOW), .FAST_DIV(FAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  // Reference model built from the requirements
  int m_e;
  int m_div [3];
  int m_cnt [3];
  int m_per [3];
  bit m_en  [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_e = 0;
      for (int i = 0; i < 3; i++) begin
        m_div[i] = 0; m_cnt[i] = 0; m_per[i] = 256; m_en[i] = 1'b0;
      end
    end else begin
      m_e = m_e + 1;
      for (int i = 0; i < 3; i++) begin
        bit tk, inc, clr;
        tk  = (i == 2) ? (m_e % FAST == 0) : (m_e % SLOW == 0);
        inc = 1'b0;
        clr = (rd_en || wr_en) && (bus_addr == 3'(4 + i));
        if (wr_en && bus_addr == 3'd0 && wr_data[i] && !m_en[i]) begin
          m_div[i] = 0; m_cnt[i] = 0;
        end else begin
          if (m_en[i] && tk) begin
            if (m_div[i] + 1 == m_per[i]) begin m_div[i] = 0; inc = 1'b1; end
            else m_div[i] = (m_div[i] + 1) % 256;
          end
          if (clr) m_cnt[i] = inc ? 1 : 0;
          else if (inc) m_cnt[i] = (m_cnt[i] + 1) % 16;
        end
      end
      if (wr_en && bus_addr == 3'd0)
        for (int i = 0; i < 3; i++) m_en[i] = wr_data[i];
      for (int i = 0; i < 3; i++)
        if (wr_en && bus_addr == 3'(1 + i)) m_per[i] = (wr_data == 0) ? 256 : int'(wr_data);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // read and compare with the model (or a fixed value when fixed_exp >= 0)
  task automatic do_rd(input logic [2:0] a, input string tag, input int fixed_exp = -1);
    int exp;
    exp = (a >= 3'd4 && a <= 3'd6) ? m_cnt[a - 4] : 0;
    if (fixed_exp >= 0) exp = fixed_exp;
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 unmapped reads
    for (int i = 0; i < 3; i++) do_rd(3'(4 + i), "R1 counter after reset", 0);
    do_rd(3'd0, "R10 control read", 0);
    do_rd(3'd1, "R10 target read", 0);
    do_rd(3'd7, "R10 unused address", 0);

    // R1: default period 256 with slow ticks
    do_wr(3'd0, 8'h07);
    idle(256 * SLOW + 8);
    for (int i = 0; i < 3; i++) do_rd(3'(4 + i), "R1 R5 default period 256");
    do_wr(3'd0, 8'h00);

    // R3 R4 R5 sweep of targets
    for (int t = 0; t <= 14; t++) begin
      int tgt, per;
      tgt = (t == 13) ? 0 : (t == 14) ? 255 : t + 1;
      per = (tgt == 0) ? 256 : tgt;
      for (int i = 0; i < 3; i++) do_wr(3'(1 + i), 8'(tgt));
      do_wr(3'd0, 8'h07);
      for (int r = 0; r < 3; r++) begin
        idle(per * SLOW + r + 1);
        for (int i = 0; i < 3; i++) do_rd(3'(4 + i), "R3 R4 R5 sweep");
      end
      do_wr(3'd0, 8'h00);
    end

    // R4 wrap modulo 16: timer 2, period 1, many events unread
    do_wr(3'd3, 8'd1);
    do_wr(3'd0, 8'h04);
    idle(45);
    do_rd(3'd6, "R4 wrap");
    do_wr(3'd0, 8'h00);

    // R2 hold while disabled; timer 1 never enabled stays 0
    do_wr(3'd1, 8'd3);
    do_wr(3'd0, 8'h01);
    idle(40);
    do_wr(3'd0, 8'h00);
    idle(200);
    do_rd(3'd4, "R2 hold disabled");
    do_rd(3'd5, "R2 disabled timer stays zero", 0);

    // R7 write clears, data ignored
    do_wr(3'd1, 8'd1);
    do_wr(3'd0, 8'h01);
    idle(30);
    do_wr(3'd0, 8'h00);
    do_wr(3'd4, 8'hFF);
    do_rd(3'd4, "R7 write clears", 0);

    // R8 re-write with bit set keeps state; rising edge clears
    do_wr(3'd0, 8'h01);
    idle(30);
    do_wr(3'd0, 8'h01);
    do_rd(3'd4, "R8 no clear without rise");
    do_wr(3'd1, 8'd3);
    idle(20);
    do_wr(3'd0, 8'h00);
    do_wr(3'd0, 8'h01);
    do_rd(3'd4, "R8 rise clears", 0);
    do_wr(3'd0, 8'h00);

    // R9 clear coinciding with increment
    do_wr(3'd1, 8'd1);
    do_wr(3'd0, 8'h01);
    idle(17);
    while ((m_e + 1) % SLOW != 0) @(negedge clk);
    do_rd(3'd4, "R6 read at increment");
    do_rd(3'd4, "R9 coincident clear keeps event", 1);
    do_rd(3'd4, "R6 read clears", 0);

    // R9 via write strobe on the increment edge
    idle(9);
    while ((m_e + 1) % SLOW != 0) @(negedge clk);
    do_wr(3'd4, 8'h00);
    do_rd(3'd4, "R9 coincident write clear", 1);
    do_wr(3'd0, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule